// File: doc/BRIEF.md
# Parallel Host Readout and Configuration Port

This block is the byte-wide host side of a data decoder. When the decoder has finished a result record of 36 bytes, it pulses `rec_ready`. The port then pulls its interrupt low and hands the record to the host one byte per read strobe. The first two bytes are status and the other 34 are corrected payload. The record store itself lives outside the block. The port shows the byte it wants on `rec_index` and takes that byte back on `rec_data`.

Each read uses two ready signals. After the host pulls `re_n` low, `rdy` drops for a fixed number of clock cycles and then rises with the byte valid. `rdy0` is a level signal: it is low while the byte is valid and goes high again once the host lets go of `re_n`.

The same data pins carry writes into five configuration registers. While `pst_n` is low the pins turn into inputs. The address and data held during that low time are stored when the strobe rises. All host strobes are taken as synchronous to `clk`.

Top module: `hostport_par`

## Requirements
- R1: The k-th completed read after a `rec_ready` pulse puts record byte k (k = 0..35) on `dat_out` during its valid phase. `rec_index` equals k during that read. Bytes 0 and 1 are the status bytes and bytes 2 to 35 are the payload.
- R2: `int_n` goes low on the clock edge after `rec_ready` is sampled high. It returns high on the edge at which a falling `re_n` is first sampled.
- R3: `rdy` goes low on the edge after a falling `re_n` is sampled and stays low for exactly `RDY_LOW_CYC` cycles (default 8). It then goes high and the byte is valid from that point.
- R4: `rdy0` is low exactly while the byte is valid. It goes high, and `dat_out` returns to 0x00, on the edge after `re_n` is sampled high.
- R5: After all 36 bytes have been read, every further read returns 0x00 and does not move the index. Reads made before any record has arrived also return 0x00.
- R6: During reset `dat_out` is 0x00, `dat_oe` is 1, and `rdy`, `rdy0` and `int_n` are 1. The configuration registers hold their defaults: addr0 0x22, addr1 0x17, addr2 0x17, addr3 7, addr4 0x00.
- R7: `dat_oe` is 0 on the edge after `pst_n` is sampled low, and it returns to 1 on the edge after `pst_n` is sampled high.
- R8: A write to `port_addr` 0, 1, 2 or 4 loads the last `port_addr`/`dat_in` values sampled while `pst_n` was low. The target register changes on the edge at which the rising `pst_n` is sampled. Values on `dat_in` after the rise do not matter.
- R9: A write to `port_addr` 5, 6 or 7 leaves all five registers unchanged.
- R10: The threshold register (`port_addr` 3) keeps only `dat_in[2:0]`.
- R11: A `rec_ready` pulse during a read ends that read: `rdy` and `rdy0` are high on the next edge. The next read then returns byte 0 of the new record.
- R12: If `re_n` returns high while `rdy` is still low, the read is dropped and the index does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rec_ready | input | 1 | One-cycle pulse: a new record is available |
| rec_data | input | 8 | Record byte selected by `rec_index` |
| rec_index | output | 6 | Index of the byte being read (36 = past the end) |
| re_n | input | 1 | Host read strobe, active low |
| rdy | output | 1 | Ready pulse, low while the byte is being prepared |
| rdy0 | output | 1 | Ready level, low while the byte is valid |
| int_n | output | 1 | Record-ready interrupt, active low |
| pst_n | input | 1 | Host store strobe, active low |
| port_addr | input | 3 | Configuration register address |
| dat_in | input | 8 | Data pins as seen from the input side |
| dat_out | output | 8 | Data pins as driven by the block |
| dat_oe | output | 1 | Data pin output enable |
| cfg_err_allow | output | 8 | Register 0 (allowed error counts) |
| cfg_blk_prot | output | 8 | Register 1 (block protection counts) |
| cfg_frm_prot | output | 8 | Register 2 (frame protection counts) |
| cfg_thresh | output | 3 | Register 3 (initial threshold code) |
| cfg_skip_blk | output | 8 | Register 4 (readout block number) |

## Verification
The readout is tried with three kinds of read. Full reads through a whole record check the byte order and the end-of-record saturation. Reads dropped while `rdy` is low tell an index that holds from one that moves early. A new record arriving during a valid phase shows whether the sequencer restarts or finishes the old byte. Writes cover every address, including the unused ones and the 3-bit threshold. `dat_in` is changed at the moment the strobe rises, so a port that samples too late gives a different result.

// File: rtl/hp_pkg.sv
package hp_pkg;

  typedef enum logic [1:0] {
    RS_IDLE  = 2'd0,
    RS_PULSE = 2'd1,
    RS_READY = 2'd2
  } rd_state_e;

  localparam int NUM_CFG   = 5;
  localparam int CFG_W     = 8;
  localparam int THR_SLOT  = 3;

  function automatic logic [CFG_W-1:0] cfg_reset_val(input int slot);
    case (slot)
      0:       return 8'h22;
      1:       return 8'h17;
      2:       return 8'h17;
      3:       return 8'h07;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [CFG_W-1:0] cfg_keep_mask(input int slot);
    return (slot == THR_SLOT) ? 8'h07 : 8'hFF;
  endfunction

endpackage

// File: rtl/hp_rd_seq.sv
module hp_rd_seq
  import hp_pkg::*;
#(
  parameter int REC_BYTES   = 36,
  parameter int RDY_LOW_CYC = 8,
  parameter int IDX_W       = $clog2(REC_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rec_ready,
  input  logic             re_n,
  output logic [IDX_W-1:0] idx,
  output logic             rdy,
  output logic             rdy0,
  output logic             byte_valid,
  output logic             int_n
);

  localparam int CNT_W = (RDY_LOW_CYC > 1) ? $clog2(RDY_LOW_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RDY_LOW_CYC - 1);
  localparam logic [IDX_W-1:0] IDX_END  = IDX_W'(REC_BYTES);

  rd_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             int_q, int_d;
  logic             re_prev_q;
  logic             re_fall;

  assign re_fall = re_prev_q & ~re_n;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    int_d   = int_q;
    if (rec_ready) begin
      state_d = RS_IDLE;
      idx_d   = '0;
      int_d   = 1'b0;
    end else begin
      if (re_fall) int_d = 1'b1;
      case (state_q)
        RS_IDLE: begin
          if (re_fall) begin
            state_d = RS_PULSE;
            cnt_d   = CNT_LOAD;
          end
        end
        RS_PULSE: begin
          if (re_n)                state_d = RS_IDLE;
          else if (cnt_q == '0)    state_d = RS_READY;
          else                     cnt_d   = cnt_q - 1'b1;
        end
        RS_READY: begin
          if (re_n) begin
            state_d = RS_IDLE;
            if (idx_q < IDX_END) idx_d = idx_q + 1'b1;
          end
        end
        default: state_d = RS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= RS_IDLE;
      cnt_q     <= '0;
      idx_q     <= IDX_END;
      int_q     <= 1'b1;
      re_prev_q <= 1'b1;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      idx_q     <= idx_d;
      int_q     <= int_d;
      re_prev_q <= re_n;
    end
  end

  assign idx        = idx_q;
  assign rdy        = (state_q != RS_PULSE);
  assign rdy0       = (state_q != RS_READY);
  assign byte_valid = (state_q == RS_READY) && (idx_q < IDX_END);
  assign int_n      = int_q;

  // R2: interrupt falls after a record-ready pulse
  a_r2_int_fall: assert property (@(posedge clk) disable iff (!rst_n)
    rec_ready |=> !int_n);

  // R3: a sampled falling read strobe starts the low pulse
  a_r3_pulse_start: assert property (@(posedge clk) disable iff (!rst_n)
    (re_prev_q && !re_n && rdy && rdy0 && !rec_ready) |=> !rdy);

  // R4: level ready releases once the strobe is back high
  a_r4_rdy0_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy0 && re_n && !rec_ready) |=> rdy0);

  // R5: index never passes the end of the record
  a_r5_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= IDX_END);

  // R11: new record restarts the sequencer
  a_r11_restart: assert property (@(posedge clk) disable iff (!rst_n)
    rec_ready |=> (idx == '0 && rdy && rdy0));

  // R12: aborted pulse leaves the index alone
  a_r12_abort_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy && re_n && !rec_ready) |=> $stable(idx));

endmodule

// File: rtl/hp_cfg_bank.sv
module hp_cfg_bank
  import hp_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            pst_n,
  input  logic [2:0]                      port_addr,
  input  logic [CFG_W-1:0]                dat_in,
  output logic [NUM_CFG-1:0][CFG_W-1:0]   cfg
);

  logic             pst_prev_q;
  logic [2:0]       addr_q;
  logic [CFG_W-1:0] din_q;
  logic             wr_fire;
  logic [NUM_CFG-1:0] wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pst_prev_q <= 1'b1;
      addr_q     <= '0;
      din_q      <= '0;
    end else begin
      pst_prev_q <= pst_n;
      if (!pst_n) begin
        addr_q <= port_addr;
        din_q  <= dat_in;
      end
    end
  end

  assign wr_fire = ~pst_prev_q & pst_n;

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_reg
    localparam logic [CFG_W-1:0] RST_V = cfg_reset_val(g);
    localparam logic [CFG_W-1:0] MASK  = cfg_keep_mask(g);
    logic [CFG_W-1:0] val_q;

    assign wr_en[g] = wr_fire && (addr_q == 3'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        val_q <= RST_V;
      else if (wr_en[g]) val_q <= din_q & MASK;
    end

    assign cfg[g] = val_q;
  end

  // R9: unused addresses change nothing
  a_r9_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && addr_q >= 3'(NUM_CFG)) |=> $stable(cfg));

  // R10: threshold register never carries upper bits
  a_r10_thr_mask: assert property (@(posedge clk) disable iff (!rst_n)
    cfg[THR_SLOT][CFG_W-1:3] == '0);

  // R8: a write reaches only the addressed register
  a_r8_one_hot_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));

endmodule

// File: rtl/hostport_par.sv
module hostport_par
  import hp_pkg::*;
#(
  parameter int REC_BYTES   = 36,
  parameter int RDY_LOW_CYC = 8,
  parameter int IDX_W       = $clog2(REC_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rec_ready,
  input  logic [7:0]       rec_data,
  output logic [IDX_W-1:0] rec_index,
  input  logic             re_n,
  output logic             rdy,
  output logic             rdy0,
  output logic             int_n,
  input  logic             pst_n,
  input  logic [2:0]       port_addr,
  input  logic [7:0]       dat_in,
  output logic [7:0]       dat_out,
  output logic             dat_oe,
  output logic [7:0]       cfg_err_allow,
  output logic [7:0]       cfg_blk_prot,
  output logic [7:0]       cfg_frm_prot,
  output logic [2:0]       cfg_thresh,
  output logic [7:0]       cfg_skip_blk
);

  logic                          byte_valid;
  logic                          oe_q;
  logic [NUM_CFG-1:0][CFG_W-1:0] cfg;

  hp_rd_seq #(
    .REC_BYTES  (REC_BYTES),
    .RDY_LOW_CYC(RDY_LOW_CYC),
    .IDX_W      (IDX_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .rec_ready (rec_ready),
    .re_n      (re_n),
    .idx       (rec_index),
    .rdy       (rdy),
    .rdy0      (rdy0),
    .byte_valid(byte_valid),
    .int_n     (int_n)
  );

  hp_cfg_bank u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .pst_n    (pst_n),
    .port_addr(port_addr),
    .dat_in   (dat_in),
    .cfg      (cfg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_q <= 1'b1;
    else        oe_q <= pst_n;
  end

  assign dat_oe        = oe_q;
  assign dat_out       = byte_valid ? rec_data : 8'h00;
  assign cfg_err_allow = cfg[0];
  assign cfg_blk_prot  = cfg[1];
  assign cfg_frm_prot  = cfg[2];
  assign cfg_thresh    = cfg[THR_SLOT][2:0];
  assign cfg_skip_blk  = cfg[4];

  // R7: pins turn to input after the store strobe is sampled low
  a_r7_dir_in: assert property (@(posedge clk) disable iff (!rst_n)
    !pst_n |=> !dat_oe);

  // R5: nothing is driven outside a valid byte phase
  a_r5_quiet_out: assert property (@(posedge clk) disable iff (!rst_n)
    rdy0 |-> dat_out == 8'h00);

endmodule

// File: tb/sim_hostport_par.sv
module sim_hostport_par;

  localparam int CLK_P   = 10;
  localparam int NB      = 36;
  localparam int RDY_LOW = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rec_ready = 1'b0;
  logic [7:0] rec_data;
  logic [5:0] rec_index;
  logic       re_n = 1'b1;
  logic       rdy, rdy0, int_n;
  logic       pst_n = 1'b1;
  logic [2:0] port_addr = 3'd0;
  logic [7:0] dat_in = 8'h00;
  logic [7:0] dat_out;
  logic       dat_oe;
  logic [7:0] cfg_err_allow, cfg_blk_prot, cfg_frm_prot, cfg_skip_blk;
  logic [2:0] cfg_thresh;

  logic [7:0] mem [NB];
  int vectors = 0;
  int fails   = 0;
  bit done    = 0;
  int cycles  = 0;

  always #(CLK_P/2) clk = ~clk;

  assign rec_data = (rec_index < 6'(NB)) ? mem[rec_index] : 8'h00;

  hostport_par u0 (
    .clk(clk), .rst_n(rst_n), .rec_ready(rec_ready), .rec_data(rec_data),
    .rec_index(rec_index), .re_n(re_n), .rdy(rdy), .rdy0(rdy0), .int_n(int_n),
    .pst_n(pst_n), .port_addr(port_addr), .dat_in(dat_in), .dat_out(dat_out),
    .dat_oe(dat_oe), .cfg_err_allow(cfg_err_allow), .cfg_blk_prot(cfg_blk_prot),
    .cfg_frm_prot(cfg_frm_prot), .cfg_thresh(cfg_thresh), .cfg_skip_blk(cfg_skip_blk)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_phase = 0;   // 0 waiting, 1 preparing, 2 byte out
  int m_wait  = 0;
  int m_pos   = NB;
  int m_irq   = 1;
  int m_reold = 1;
  int m_pold  = 1;
  int m_addr  = 0;
  int m_din   = 0;
  int m_oe    = 1;
  int m_cfg [5] = '{8'h22, 8'h17, 8'h17, 7, 0};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_wait = 0; m_pos = NB; m_irq = 1; m_reold = 1;
      m_pold = 1; m_addr = 0; m_din = 0; m_oe = 1;
      m_cfg = '{8'h22, 8'h17, 8'h17, 7, 0};
    end else begin
      bit fall;
      fall = (m_reold == 1) && (re_n == 1'b0);
      if (rec_ready) begin
        m_pos = 0; m_irq = 0; m_phase = 0;
      end else begin
        if (fall) m_irq = 1;
        if (m_phase == 0) begin
          if (fall) begin m_phase = 1; m_wait = RDY_LOW; end
        end else if (m_phase == 1) begin
          if (re_n) m_phase = 0;
          else begin
            m_wait = m_wait - 1;
            if (m_wait == 0) m_phase = 2;
          end
        end else begin
          if (re_n) begin
            m_phase = 0;
            if (m_pos < NB) m_pos = m_pos + 1;
          end
        end
      end
      m_reold = int'(re_n);
      if (m_pold == 0 && pst_n) begin
        if (m_addr == 3) m_cfg[3] = m_din & 7;
        else if (m_addr < 5) m_cfg[m_addr] = m_din;
      end
      if (!pst_n) begin m_addr = int'(port_addr); m_din = int'(dat_in); end
      m_pold = int'(pst_n);
      m_oe   = int'(pst_n);
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      int exp_d;
      exp_d = (m_phase == 2 && m_pos < NB) ? int'(mem[m_pos]) : 0;
      check("R3", "rdy", int'(rdy), (m_phase == 1) ? 0 : 1);
      check("R4", "rdy0", int'(rdy0), (m_phase == 2) ? 0 : 1);
      check("R2", "int_n", int'(int_n), m_irq);
      check((m_pos >= NB) ? "R5" : "R1", "dat_out", int'(dat_out), exp_d);
      check("R7", "dat_oe", int'(dat_oe), m_oe);
      check("R8", "cfg0", int'(cfg_err_allow), m_cfg[0]);
      check("R8", "cfg1", int'(cfg_blk_prot), m_cfg[1]);
      check("R8", "cfg2", int'(cfg_frm_prot), m_cfg[2]);
      check("R10", "cfg3", int'(cfg_thresh), m_cfg[3]);
      check("R8", "cfg4", int'(cfg_skip_blk), m_cfg[4]);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 50000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic new_record(input int seed);
    for (int i = 0; i < NB; i++) mem[i] = 8'((seed * 37 + i * 11 + 5) ^ (i << 3));
    rec_ready = 1'b1;
    step(1);
    rec_ready = 1'b0;
    check("R2", "int_n after ready", int'(int_n), 0);
  endtask

  task automatic do_read(input int exp, input string req);
    re_n = 1'b0;
    step(1);
    check("R3", "rdy low first cycle", int'(rdy), 0);
    step(RDY_LOW);
    check("R3", "rdy back high", int'(rdy), 1);
    check(req, "byte", int'(dat_out), exp);
    check("R4", "rdy0 low with data", int'(rdy0), 0);
    re_n = 1'b1;
    step(1);
    check("R4", "rdy0 released", int'(rdy0), 1);
    check("R4", "data cleared", int'(dat_out), 0);
    step(1);
  endtask

  task automatic do_write(input int addr, input int data);
    pst_n = 1'b0; port_addr = 3'(addr); dat_in = 8'(data);
    step(1);
    check("R7", "dat_oe low", int'(dat_oe), 0);
    step(2);
    pst_n = 1'b1; dat_in = ~8'(data); port_addr = ~3'(addr);
    step(1);
    check("R7", "dat_oe high", int'(dat_oe), 1);
    step(1);
  endtask

  initial begin
    rst_n = 1'b0;
    for (int i = 0; i < NB; i++) mem[i] = 8'h00;
    step(3);
    check("R6", "reset rdy", int'(rdy), 1);
    check("R6", "reset rdy0", int'(rdy0), 1);
    check("R6", "reset int_n", int'(int_n), 1);
    check("R6", "reset dat_out", int'(dat_out), 0);
    check("R6", "reset dat_oe", int'(dat_oe), 1);
    check("R6", "reset cfg0", int'(cfg_err_allow), 8'h22);
    check("R6", "reset cfg3", int'(cfg_thresh), 7);
    rst_n = 1'b1;
    step(2);

    do_read(0, "R5");                       // no record yet

    new_record(1);
    for (int k = 0; k < NB; k++) do_read(int'(mem[k]), "R1");
    check("R2", "int_n after first read", int'(int_n), 1);
    do_read(0, "R5");
    do_read(0, "R5");

    new_record(2);
    do_read(int'(mem[0]), "R1");
    re_n = 1'b0; step(3); re_n = 1'b1; step(2);   // R12 abort
    check("R12", "rdy after abort", int'(rdy), 1);
    do_read(int'(mem[1]), "R12");
    do_read(int'(mem[2]), "R1");

    re_n = 1'b0; step(RDY_LOW + 2);               // R11 mid-read record
    mem[0] = 8'h5A;
    rec_ready = 1'b1; step(1); rec_ready = 1'b0;
    check("R11", "rdy0 after ready", int'(rdy0), 1);
    re_n = 1'b1; step(2);
    do_read(8'h5A, "R11");

    do_write(0, 8'h3C);
    check("R8", "cfg0 written", int'(cfg_err_allow), 8'h3C);
    do_write(4, 8'hBD);
    check("R8", "cfg4 written", int'(cfg_skip_blk), 8'hBD);
    do_write(3, 8'hFA);
    check("R10", "thresh masked", int'(cfg_thresh), 2);
    for (int a = 5; a < 8; a++) begin
      do_write(a, 8'h99);
      check("R9", "cfg1 unchanged", int'(cfg_blk_prot), 8'h17);
      check("R9", "cfg2 unchanged", int'(cfg_frm_prot), 8'h17);
      check("R9", "cfg0 unchanged", int'(cfg_err_allow), 8'h3C);
    end
    do_write(1, 8'h41);
    do_write(2, 8'h06);
    check("R8", "cfg2 written", int'(cfg_frm_prot), 8'h06);

    step(3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule